// File: doc/BRIEF.md
# DMA Channel Request and Bandwidth Sequencer

This block sequences the bus tenure of one DMA channel. A rising edge on the selected request line, internal or external, starts work. The sequencer then raises a bus request, issues one transfer strobe for each granted transfer and waits for the transfer-done pulse of that transfer. It decrements a byte counter by the transfer size and decides whether to keep the bus, release it or finish. Address generation and data movement live outside; each transfer is a strobe answered by an acknowledge pulse.

**Modes.** Two modes exist.

- **Cycle-steal mode** performs one transfer per request edge.
- **Continuous mode** keeps transferring until one of these happens: the byte count runs out, software writes DONE, or a bandwidth quota is used up. When the quota is used up, the channel lets go of the bus for a cycle and then comes back.

**Completion and vector.** On completion a sticky done flag is set and a one-cycle interrupt pulse is raised. An 8-bit vector register supplies the interrupt vector during an acknowledge cycle.

**States and transitions.**

- `ST_IDLE` goes to `ST_ARB` when a request is pending, the flag is clear and the count is nonzero. It goes to `ST_FINISH` on a DONE write.
- `ST_ARB` (bus requested) goes to `ST_XFER` on grant, which is also the cycle of the strobe. It goes to `ST_FINISH` on a DONE write.
- `ST_XFER` waits for the acknowledge. It then goes to one of:
  - `ST_FINISH`, if the count is exhausted or DONE was written;
  - `ST_IDLE`, in cycle-steal mode;
  - `ST_YIELD`, if the quota is reached;
  - `ST_ARB`, otherwise.
- `ST_YIELD` goes to `ST_ARB`, or to `ST_FINISH` if DONE was written.
- `ST_FINISH` goes to `ST_IDLE`.

Top module: `dma_seq_top`

## Requirements
- R1: The request source select input picks the line: 1 selects `req_ext`, 0 selects `req_int`. Only a rising edge of the selected line is taken as a request; edges on the other line have no effect.
- R2: With `cfg_steal`=1, each request edge yields exactly one strobed transfer. After its acknowledge, `bus_req` goes low.
- R3: With `cfg_steal`=0 and `cfg_bw`=000, one request edge runs transfers back to back until the byte count reaches zero. `bus_req` stays high for the whole run.
- R4: With `cfg_steal`=0 and `cfg_bw`=n (1..7), after every 2^(n+1) acknowledged transfers the channel drops `bus_req` for exactly one cycle. It then re-requests if bytes remain.
- R5: Each acknowledged transfer decrements `byte_count` by the size step. `cfg_size` 00 gives 1, 01 gives 2, and 10 or 11 give 4. The count saturates at zero. A write with `bc_wr_en` loads `bc_wr_data`.
- R6: A pulse on `done_wr` stops an active run. A transfer already strobed still completes and is counted; no further strobe is issued.
- R7: Every run ends with a one-cycle `irq` pulse, after which `done_flag` reads 1.
- R8: While `done_flag` is 1, request edges are discarded and no transfer starts. `stat_clr` clears the flag, after which new request edges are honoured.
- R9: `xfer_strobe` is high only in cycles where `bus_grant` and `bus_req` are high. `bus_req` is low whenever the channel is idle, yielding or finishing.
- R10: The vector register resets to 0x0F and is loaded by `vec_wr_en`. `vec_out` carries it only while `mod_sel` and `vec_oe` are both high, and is 0x00 otherwise.
- R11: After reset, `bus_req`, `xfer_strobe`, `irq` and `done_flag` are 0 and `byte_count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_steal | input | 1 | 1 = cycle-steal, 0 = continuous |
| cfg_ext_sel | input | 1 | 1 = external request line, 0 = internal |
| cfg_bw | input | 3 | Bandwidth control, 000 = maximum rate |
| cfg_size | input | 2 | Transfer size code |
| req_int | input | 1 | Internal request line |
| req_ext | input | 1 | External request line |
| bc_wr_en | input | 1 | Byte count write strobe |
| bc_wr_data | input | BC_W | Byte count write value |
| done_wr | input | 1 | Software writes 1 to DONE |
| stat_clr | input | 1 | Clears the done flag |
| vec_wr_en | input | 1 | Vector register write strobe |
| vec_wr_data | input | 8 | Vector register write value |
| mod_sel | input | 1 | Module select of an acknowledge cycle |
| vec_oe | input | 1 | Vector output enable |
| vec_out | output | 8 | Interrupt vector, zero when not enabled |
| bus_grant | input | 1 | Bus granted to this channel |
| bus_req | output | 1 | Bus request |
| xfer_strobe | output | 1 | Start of one transfer |
| xfer_ack | input | 1 | Transfer complete pulse |
| byte_count | output | BC_W | Remaining byte count |
| done_flag | output | 1 | Sticky completion status |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Request timing:
- A request edge is latched at the first clock edge.
- `bus_req` rises one clock later.
- `xfer_strobe` is combinational in the arbitration cycle, so it appears as soon as grant is high.

Per-transfer and completion timing:
- The byte count changes at the edge that samples `xfer_ack`.
- `irq` follows in the next cycle, and `done_flag` reads 1 one edge after that.
- `vec_out` follows its enables in the same cycle.

The bench drives inputs just after a rising edge and samples at the falling edge. It acknowledges each strobe one cycle later, counts strobes, `bus_req` falls and `irq` pulses per scenario, and compares the totals and the final count with values computed from the byte count, step and quota.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    // width of the per-tenure transfer counter; quota 2^8 needs 9 bits
    localparam int QCNT_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARB    = 3'd1,
        ST_XFER   = 3'd2,
        ST_YIELD  = 3'd3,
        ST_FINISH = 3'd4
    } seq_state_t;

    // bytes moved per transfer for a size code
    function automatic logic [2:0] step_of(input logic [1:0] code);
        logic [2:0] s;
        unique case (code)
            2'b00:   s = 3'd1;
            2'b01:   s = 3'd2;
            default: s = 3'd4;
        endcase
        return s;
    endfunction

    // transfers per tenure for a nonzero bandwidth code: 2^(code+1)
    function automatic logic [QCNT_W-1:0] quota_of(input logic [2:0] code);
        logic [QCNT_W-1:0] q;
        q = '0;
        q[int'(code) + 1] = 1'b1;
        return q;
    endfunction

endpackage

// File: rtl/dma_req_latch.sv
module dma_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_ext,
    input  logic req_int,
    input  logic req_ext,
    input  logic block,
    input  logic consume,
    output logic pending
);
    logic line;
    logic line_q;
    logic rise;

    assign line = sel_ext ? req_ext : req_int;
    assign rise = line & ~line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q  <= 1'b0;
            pending <= 1'b0;
        end else begin
            line_q <= line;
            // a new edge wins over a consume in the same cycle
            if (rise && !block) begin
                pending <= 1'b1;
            end else if (consume) begin
                pending <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_byte_cnt.sv
module dma_byte_cnt #(
    parameter int BC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [BC_W-1:0] wr_data,
    input  logic            dec_en,
    input  logic [2:0]      step,
    output logic [BC_W-1:0] count,
    output logic            is_zero,
    output logic            last_xfer
);
    logic [BC_W-1:0] step_w;

    assign step_w    = BC_W'(step);
    assign is_zero   = (count == '0);
    assign last_xfer = (count <= step_w);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_en) begin
            count <= wr_data;
        end else if (dec_en) begin
            count <= last_xfer ? '0 : count - step_w;
        end
    end
endmodule

// File: rtl/dma_quota_cnt.sv
module dma_quota_cnt
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       inc,
    input  logic [2:0] bw,
    output logic       quota_hit
);
    logic [QCNT_W-1:0] done_cnt;
    logic [QCNT_W-1:0] limit;

    assign limit     = quota_of(bw);
    // true while the transfer being acknowledged fills the quota
    assign quota_hit = (bw != 3'd0) && ((done_cnt + QCNT_W'(1)) == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_cnt <= '0;
        end else if (clr) begin
            done_cnt <= '0;
        end else if (inc) begin
            done_cnt <= done_cnt + QCNT_W'(1);
        end
    end
endmodule

// File: rtl/dma_vec_reg.sv
module dma_vec_reg #(
    parameter logic [7:0] VEC_RST = 8'h0F
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       mod_sel,
    input  logic       oe,
    output logic [7:0] vec_out
);
    logic [7:0] vec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= VEC_RST;
        end else if (wr_en) begin
            vec_q <= wr_data;
        end
    end

    assign vec_out = (mod_sel && oe) ? vec_q : 8'h00;
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic steal,
    input  logic pending,
    input  logic bc_zero,
    input  logic bc_last,
    input  logic quota_hit,
    input  logic grant,
    input  logic ack,
    input  logic done_wr,
    input  logic stat_clr,
    output logic bus_req,
    output logic strobe,
    output logic dec_en,
    output logic q_inc,
    output logic q_clr,
    output logic consume,
    output logic irq,
    output logic done_flag
);
    seq_state_t state;
    seq_state_t state_nx;
    logic       stop_q;
    logic       stop;

    assign stop = stop_q | done_wr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // DONE latch and sticky completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stop_q    <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            if (state == ST_FINISH) begin
                stop_q <= 1'b0;
            end else if (done_wr) begin
                stop_q <= 1'b1;
            end
            if (state == ST_FINISH) begin
                done_flag <= 1'b1;
            end else if (stat_clr) begin
                done_flag <= 1'b0;
            end
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (stop) begin
                    state_nx = ST_FINISH;
                end else if (pending && !done_flag && !bc_zero) begin
                    state_nx = ST_ARB;
                end
            end
            ST_ARB: begin
                if (stop) begin
                    state_nx = ST_FINISH;
                end else if (grant) begin
                    state_nx = ST_XFER;
                end
            end
            ST_XFER: begin
                if (ack) begin
                    if (bc_last || stop) begin
                        state_nx = ST_FINISH;
                    end else if (steal) begin
                        state_nx = ST_IDLE;
                    end else if (quota_hit) begin
                        state_nx = ST_YIELD;
                    end else begin
                        state_nx = ST_ARB;
                    end
                end
            end
            ST_YIELD: begin
                state_nx = stop ? ST_FINISH : ST_ARB;
            end
            ST_FINISH: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        bus_req = 1'b0;
        strobe  = 1'b0;
        dec_en  = 1'b0;
        q_inc   = 1'b0;
        q_clr   = 1'b0;
        consume = 1'b0;
        irq     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                q_clr = 1'b1;
            end
            ST_ARB: begin
                bus_req = 1'b1;
                strobe  = grant && !stop;
            end
            ST_XFER: begin
                bus_req = 1'b1;
                dec_en  = ack;
                q_inc   = ack;
                consume = ack && steal;
            end
            ST_YIELD: begin
                q_clr = 1'b1;
            end
            ST_FINISH: begin
                q_clr   = 1'b1;
                consume = 1'b1;
                irq     = 1'b1;
            end
            default: begin
                q_clr = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dma_seq_top.sv
module dma_seq_top
    import dma_seq_pkg::*;
#(
    parameter int         BC_W    = 16,
    parameter logic [7:0] VEC_RST = 8'h0F
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_steal,
    input  logic            cfg_ext_sel,
    input  logic [2:0]      cfg_bw,
    input  logic [1:0]      cfg_size,
    input  logic            req_int,
    input  logic            req_ext,
    input  logic            bc_wr_en,
    input  logic [BC_W-1:0] bc_wr_data,
    input  logic            done_wr,
    input  logic            stat_clr,
    input  logic            vec_wr_en,
    input  logic [7:0]      vec_wr_data,
    input  logic            mod_sel,
    input  logic            vec_oe,
    output logic [7:0]      vec_out,
    input  logic            bus_grant,
    output logic            bus_req,
    output logic            xfer_strobe,
    input  logic            xfer_ack,
    output logic [BC_W-1:0] byte_count,
    output logic            done_flag,
    output logic            irq
);
    logic pending;
    logic consume;
    logic bc_zero;
    logic bc_last;
    logic dec_en;
    logic q_inc;
    logic q_clr;
    logic quota_hit;

    dma_req_latch u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_ext (cfg_ext_sel),
        .req_int (req_int),
        .req_ext (req_ext),
        .block   (done_flag),
        .consume (consume),
        .pending (pending)
    );

    dma_byte_cnt #(.BC_W(BC_W)) u_bc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bc_wr_en),
        .wr_data   (bc_wr_data),
        .dec_en    (dec_en),
        .step      (step_of(cfg_size)),
        .count     (byte_count),
        .is_zero   (bc_zero),
        .last_xfer (bc_last)
    );

    dma_quota_cnt u_quota (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (q_clr),
        .inc       (q_inc),
        .bw        (cfg_bw),
        .quota_hit (quota_hit)
    );

    dma_vec_reg #(.VEC_RST(VEC_RST)) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (vec_wr_en),
        .wr_data (vec_wr_data),
        .mod_sel (mod_sel),
        .oe      (vec_oe),
        .vec_out (vec_out)
    );

    dma_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .steal     (cfg_steal),
        .pending   (pending),
        .bc_zero   (bc_zero),
        .bc_last   (bc_last),
        .quota_hit (quota_hit),
        .grant     (bus_grant),
        .ack       (xfer_ack),
        .done_wr   (done_wr),
        .stat_clr  (stat_clr),
        .bus_req   (bus_req),
        .strobe    (xfer_strobe),
        .dec_en    (dec_en),
        .q_inc     (q_inc),
        .q_clr     (q_clr),
        .consume   (consume),
        .irq       (irq),
        .done_flag (done_flag)
    );
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
    parameter int BC_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_steal,
    input logic            bus_grant,
    input logic            bus_req,
    input logic            xfer_strobe,
    input logic            xfer_ack,
    input logic            irq,
    input logic            done_flag,
    input logic            stat_clr,
    input logic            bc_wr_en,
    input logic [BC_W-1:0] byte_count,
    input logic            mod_sel,
    input logic            vec_oe,
    input logic [7:0]      vec_out
);
    p_strobe_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_strobe |-> (bus_grant && bus_req));

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_clr) |=> done_flag);

    p_flag_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_flag |-> !xfer_strobe);

    p_count_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bc_wr_en |=> (byte_count <= $past(byte_count)));

    p_vec_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mod_sel && vec_oe) |-> (vec_out == 8'h00));

    p_steal_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_steal && xfer_ack && bus_req && bus_grant && !xfer_strobe) |=> !bus_req);
endmodule

bind dma_seq_top dma_seq_chk #(.BC_W(BC_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_steal   (cfg_steal),
    .bus_grant   (bus_grant),
    .bus_req     (bus_req),
    .xfer_strobe (xfer_strobe),
    .xfer_ack    (xfer_ack),
    .irq         (irq),
    .done_flag   (done_flag),
    .stat_clr    (stat_clr),
    .bc_wr_en    (bc_wr_en),
    .byte_count  (byte_count),
    .mod_sel     (mod_sel),
    .vec_oe      (vec_oe),
    .vec_out     (vec_out)
);

// File: tb/dma_seq_top_test.sv
`timescale 1ns/1ps
module dma_seq_top_test;
    localparam int BC_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_steal = 1'b0;
    logic            cfg_ext_sel = 1'b0;
    logic [2:0]      cfg_bw = 3'd0;
    logic [1:0]      cfg_size = 2'd0;
    logic            req_int = 1'b0;
    logic            req_ext = 1'b0;
    logic            bc_wr_en = 1'b0;
    logic [BC_W-1:0] bc_wr_data = '0;
    logic            done_wr = 1'b0;
    logic            stat_clr = 1'b0;
    logic            vec_wr_en = 1'b0;
    logic [7:0]      vec_wr_data = 8'h00;
    logic            mod_sel = 1'b0;
    logic            vec_oe = 1'b0;
    logic [7:0]      vec_out;
    logic            bus_grant;
    logic            bus_req;
    logic            xfer_strobe;
    logic            xfer_ack = 1'b0;
    logic [BC_W-1:0] byte_count;
    logic            done_flag;
    logic            irq;

    logic grant_en = 1'b1;
    assign bus_grant = grant_en;

    int n_chk = 0;
    int n_bad = 0;
    int n_strobe = 0;
    int n_fall = 0;
    int n_irq = 0;
    int cyc = 0;
    logic strobe_d = 1'b0;
    logic req_d = 1'b0;

    always #5 clk = ~clk;

    dma_seq_top #(.BC_W(BC_W)) uut (.*);

    // responder and monitor: acknowledge each strobe one cycle later
    always @(negedge clk) begin
        xfer_ack = strobe_d;
        strobe_d = xfer_strobe;
        if (xfer_strobe) n_strobe++;
        if (req_d && !bus_req) n_fall++;
        req_d = bus_req;
        if (irq) n_irq++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr_mon();
        n_strobe = 0; n_fall = 0; n_irq = 0;
    endtask

    task automatic load_bc(input int v);
        tick(1); bc_wr_en = 1'b1; bc_wr_data = BC_W'(v);
        tick(1); bc_wr_en = 1'b0;
    endtask

    task automatic pulse_req(input bit ext);
        if (ext) req_ext = 1'b1; else req_int = 1'b1;
        tick(1);
        req_ext = 1'b0; req_int = 1'b0;
    endtask

    task automatic clear_flag();
        stat_clr = 1'b1; tick(1); stat_clr = 1'b0; tick(1);
    endtask

    task automatic wait_flag();
        for (int i = 0; i < 4000 && !done_flag; i++) tick(1);
        tick(2);
    endtask

    function automatic int step_f(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    function automatic int nxfer_f(input int bc, input int code);
        return (bc + step_f(code) - 1) / step_f(code);
    endfunction

    function automatic int falls_f(input int n, input int bw);
        int q;
        if (bw == 0) return 1;
        q = 1 << (bw + 1);
        return (n - 1) / q + 1;
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        tick(3);
        @(negedge clk);
        // R11 reset state
        chk(bus_req == 1'b0, "R11 bus_req", int'(bus_req), 0);
        chk(done_flag == 1'b0 && irq == 1'b0, "R11 flag/irq", int'(done_flag), 0);
        chk(byte_count == 0, "R11 count", int'(byte_count), 0);
        mod_sel = 1'b1; vec_oe = 1'b1; #1;
        chk(vec_out == 8'h0F, "R10 vector reset", int'(vec_out), 15);
        mod_sel = 1'b0; vec_oe = 1'b0;
        rst_n = 1'b1;
        tick(2);

        // R10 vector write and output gating
        vec_wr_en = 1'b1; vec_wr_data = 8'hA5; tick(1); vec_wr_en = 1'b0;
        mod_sel = 1'b1; #1;
        chk(vec_out == 8'h00, "R10 only select", int'(vec_out), 0);
        vec_oe = 1'b1; #1;
        chk(vec_out == 8'hA5, "R10 both enables", int'(vec_out), 165);
        mod_sel = 1'b0; #1;
        chk(vec_out == 8'h00, "R10 only enable", int'(vec_out), 0);
        vec_oe = 1'b0;

        // R2 cycle steal: one transfer per request
        cfg_steal = 1'b1; cfg_size = 2'd0; load_bc(10); clr_mon();
        pulse_req(1'b0); tick(10);
        chk(n_strobe == 1, "R2 one per request", n_strobe, 1);
        chk(n_fall == 1 && bus_req == 1'b0, "R2 request dropped", n_fall, 1);
        chk(byte_count == 9, "R5 step 1", int'(byte_count), 9);
        for (int i = 0; i < 3; i++) begin pulse_req(1'b0); tick(8); end
        chk(n_strobe == 4, "R2 three more", n_strobe, 4);

        // R1 source select
        cfg_ext_sel = 1'b1; clr_mon();
        pulse_req(1'b0); tick(8);
        chk(n_strobe == 0, "R1 unselected line", n_strobe, 0);
        pulse_req(1'b1); tick(8);
        chk(n_strobe == 1, "R1 selected ext", n_strobe, 1);
        cfg_ext_sel = 1'b0;

        // R5 saturation at zero: count 5, size 4 -> 1, then 0 and finish
        cfg_size = 2'd2; load_bc(5); clr_mon();
        pulse_req(1'b0); tick(8); pulse_req(1'b0); tick(8);
        chk(byte_count == 0, "R5 saturate", int'(byte_count), 0);
        chk(n_strobe == 2 && done_flag == 1'b1, "R7 steal end flag", n_strobe, 2);
        chk(n_irq == 1, "R7 single irq", n_irq, 1);

        // R8 requests discarded while flag set
        load_bc(8); cfg_size = 2'd0; clr_mon();
        pulse_req(1'b0); tick(6);
        chk(n_strobe == 0, "R8 blocked by flag", n_strobe, 0);
        clear_flag(); tick(4);
        chk(n_strobe == 0, "R8 edge discarded", n_strobe, 0);
        pulse_req(1'b0); tick(8);
        chk(n_strobe == 1, "R8 honoured after clear", n_strobe, 1);

        // R3 continuous max rate, size 4, 20 bytes -> 5 transfers, no drop
        cfg_steal = 1'b0; cfg_bw = 3'd0; cfg_size = 2'd2; load_bc(20); clr_mon();
        pulse_req(1'b0); wait_flag();
        chk(n_strobe == 5, "R3 transfer count", n_strobe, 5);
        chk(n_fall == 1, "R3 bus held", n_fall, 1);
        chk(n_irq == 1 && done_flag, "R7 irq once", n_irq, 1);
        clear_flag();

        // R4 limited rate bw=1 (quota 4), 10 transfers -> two yields
        cfg_bw = 3'd1; cfg_size = 2'd0; load_bc(10); clr_mon();
        pulse_req(1'b0); wait_flag();
        chk(n_strobe == 10, "R4 transfers", n_strobe, 10);
        chk(n_fall == 3, "R4 yields", n_fall, 3);
        clear_flag();

        // R9 no strobe without grant
        cfg_bw = 3'd0; load_bc(3); clr_mon(); grant_en = 1'b0;
        pulse_req(1'b0); tick(20);
        chk(n_strobe == 0, "R9 no grant no strobe", n_strobe, 0);
        chk(bus_req == 1'b1, "R9 request held", int'(bus_req), 1);
        grant_en = 1'b1; wait_flag();
        chk(n_strobe == 3, "R9 runs after grant", n_strobe, 3);
        clear_flag();

        // R6 DONE write stops a long run
        load_bc(100); clr_mon();
        pulse_req(1'b0); tick(9);
        done_wr = 1'b1; tick(1); done_wr = 1'b0;
        wait_flag();
        chk(done_flag == 1'b1, "R6 flag", int'(done_flag), 1);
        chk(n_strobe > 0 && n_strobe < 100, "R6 stopped early", n_strobe, 5);
        chk(int'(byte_count) == 100 - n_strobe, "R6 in-flight counted",
            int'(byte_count), 100 - n_strobe);
        clear_flag();

        // R3/R4/R5 random continuous runs
        for (int k = 0; k < 25; k++) begin
            int bc;
            int sz;
            int bw;
            int n;
            bc = 1 + int'($urandom_range(0, 79));
            sz = int'($urandom_range(0, 3));
            bw = int'($urandom_range(0, 3));
            cfg_size = 2'(sz); cfg_bw = 3'(bw); cfg_ext_sel = 1'($urandom_range(0, 1));
            load_bc(bc); clr_mon();
            pulse_req(cfg_ext_sel); wait_flag();
            n = nxfer_f(bc, sz);
            chk(n_strobe == n, "R5 random transfers", n_strobe, n);
            chk(n_fall == falls_f(n, bw), "R4 random releases", n_fall, falls_f(n, bw));
            chk(byte_count == 0 && n_irq == 1, "R7 random end", int'(byte_count), 0);
            clear_flag();
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule